// File: doc/BRIEF.md
# BCD Calendar Time Counter with 12/24-Hour Modes

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of week, date, month and a two-digit year. A built-in prescaler divides the system clock down to a one-second tick. Each tick advances the seconds field, and carries ripple up through minutes, hours, days, months and years. A bit inside the hour field selects 24-hour counting or 12-hour counting. In 12-hour counting, a second bit of the hour field marks PM.

A host loads the time through a simple register write port. The port takes writes only while a write-enable control bit is set, and that bit clears on reset. Any accepted time write halts counting. A write-complete strobe, given while the enable bit is set, starts counting again and zeroes the prescaler phase. The first new second therefore arrives exactly one full prescaler period after the strobe. The serial bus front end, alarms and status flags sit outside this block.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 8'h12 (12-hour mode, PM clear, hour 12), day of week 0, date 01, month 01, year 00. The write-enable bit is 0 and counting is stopped.
- R2: A host write (`host_we`) changes no field while the write-enable bit is 0. The bit takes the value of `ctl_wen_val` on a cycle with `ctl_we` high.
- R3: `wr_done` with the write-enable bit at 1 starts counting and zeroes the prescaler. `tick_1hz` is high in the cycle that ends at the DIV-th rising edge after the edge that samples `wr_done`, and the seconds field changes on that DIV-th edge. `wr_done` with the enable bit at 0 has no effect.
- R4: Seconds and minutes count in BCD from 00 to 59. A field at 59 returns to 00 and carries into the next field.
- R5: With hour bit 7 at 1 (24-hour mode), bits 5:0 hold BCD 00 to 23. Hour 23 returns to 00 and advances the day.
- R6: With hour bit 7 at 0 (12-hour mode), bits 4:0 hold BCD hours in the order 12, 01, ..., 11, and bit 5 is the PM flag (1 = PM). Going from 11 to 12 toggles PM. Going from 11 PM to 12 AM advances the day.
- R7: The day of week counts 0 to 6, advancing once per day and returning from 6 to 0.
- R8: Months 01, 03, 05, 07, 08, 10 and 12 have 31 days. Months 04, 06, 09 and 11 have 30. Month 02 has 28 in years not divisible by 4. After the last day, the date returns to 01 and the month advances.
- R9: Month 02 has 29 days when the year value is divisible by 4, and year 00 counts as such a year.
- R10: Month 12 rolls to 01 and advances the year, and year 99 wraps to 00.
- R11: An accepted time write halts counting. A tick in the same cycle is dropped, so the written value stands and no other field moves. Counting resumes only after a valid `wr_done`.
- R12: Time register addresses are 0 seconds, 1 minutes, 2 hour, 3 day of week (data bits 2:0), 4 date, 5 month and 6 year. Address 7 is ignored: it neither changes a field nor halts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Load strobe for the write-enable bit |
| ctl_wen_val | input | 1 | New value of the write-enable bit |
| host_we | input | 1 | Time register write strobe |
| host_addr | input | 3 | Time register address |
| host_wdata | input | 8 | Time register write data (BCD) |
| wr_done | input | 1 | Write-complete strobe: restarts counting and prescaler |
| tick_1hz | output | 1 | One-cycle pulse preceding each one-second advance |
| t_sec | output | 8 | Seconds, BCD |
| t_min | output | 8 | Minutes, BCD |
| t_hour | output | 8 | Hour with mode bit 7 and PM bit 5 |
| t_dow | output | 3 | Day of week 0 to 6 |
| t_date | output | 8 | Date, BCD |
| t_month | output | 8 | Month, BCD |
| t_year | output | 8 | Two-digit year, BCD |

## Verification
The bench aims at the carry chain at its edges: 23:59:59 on 31 December of year 99, 11:59:59 on both sides of noon in 12-hour mode, and the end of February in years 00, 04 and 05. A wrong month-length or leap decode would show 02-29 in year 05, or skip straight from 02-28 to 03-01 in year 04. A PM flag toggled at 12 instead of at 11 would put the day change at noon. The bench also times the first tick after the write-complete strobe to the cycle, so a prescaler that keeps its old phase reads early or late. It places a host write exactly on a tick edge, where a design that lets the tick win shows a bumped seconds value. Random valid times near minute and hour boundaries, in both hour modes, are compared each second against a bench model kept in binary.

// File: rtl/cal_pkg.sv
// Package: shared write-port type, register addresses and BCD helpers
// for the calendar time counter. Assumes all values are packed BCD.
package cal_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_DOW   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_DATE  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_MONTH = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_YEAR  = 3'd6;

    // One host write already qualified by the write-enable bit
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_wr_t;

    // Add one to a two-digit BCD value (caller handles the wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit year divisible by four (no century exception)
    function automatic logic is_leap(input logic [7:0] y);
        return ((int'(y[7:4]) * 10 + int'(y[3:0])) % 4) == 0;
    endfunction

    // Last date of a month, in BCD
    function automatic logic [7:0] last_day(input logic [7:0] m,
                                            input logic [7:0] y);
        if (m == 8'h02)
            return is_leap(y) ? 8'h29 : 8'h28;
        else if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11)
            return 8'h30;
        else
            return 8'h31;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Module: cal_prescaler
// Divides the system clock by DIV to make a one-cycle tick. Counts only
// while run is high. restart zeroes the phase, so the next tick lands
// DIV cycles later. Assumes DIV >= 2.
module cal_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Phase counter: held at zero when stopped, zeroed on restart
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Tick marks the last cycle of each period
    always_comb tick = run && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_chk
            // R3: after a restart the tick cannot come in the next cycle
            a_r3_restart_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/cal_sexa.sv
// Module: cal_sexa
// One BCD field counting 00..59 (seconds or minutes). It loads from the
// host port when the write hits ADDR, otherwise advances on inc and
// raises carry when it wraps. Assumes the host loads valid BCD.
module cal_sexa
    import cal_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR = ADR_SEC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  host_wr_t   wr,
    output logic [7:0] value,
    output logic       carry
);
    logic hit;

    // Host write decode and wrap detect
    always_comb begin
        hit   = wr.en && (wr.addr == ADDR);
        carry = inc && (value == 8'h59);
    end

    // Field register: host load has priority over counting
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= 8'h00;
        else if (hit)
            value <= wr.data;
        else if (inc)
            value <= (value == 8'h59) ? 8'h00 : bcd_inc(value);
    end

    // R4: 59 wraps to 00
    a_r4_wrap59: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !hit && value == 8'h59 |=> value == 8'h00);
    // R2: without an advance or a write the field holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !hit |=> $stable(value));

endmodule

// File: rtl/cal_hour.sv
// Module: cal_hour
// The hour register. Bit 7 selects 24-hour counting. In 12-hour counting
// bit 5 is the PM flag and bits 4:0 run 12,01..11. carry marks the end of
// a day. Assumes the host writes an hour that is valid for the mode.
module cal_hour
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  host_wr_t   wr,
    output logic [7:0] hour,
    output logic       carry
);
    logic       hit;
    logic       mode24;
    logic       pm;
    logic [7:0] nxt;
    logic [7:0] inc24;
    logic [7:0] inc12;

    // Next hour value and day carry for both modes
    always_comb begin
        hit    = wr.en && (wr.addr == ADR_HOUR);
        mode24 = hour[7];
        pm     = hour[5];
        inc24  = bcd_inc({2'b00, hour[5:0]});
        inc12  = bcd_inc({3'b000, hour[4:0]});
        carry  = 1'b0;
        if (mode24) begin
            if (hour[5:0] == 6'h23) begin
                nxt   = {hour[7:6], 6'h00};
                carry = inc;
            end else begin
                nxt = {hour[7:6], inc24[5:0]};
            end
        end else begin
            if (hour[4:0] == 5'h11) begin
                nxt   = {hour[7:6], ~pm, 5'h12};
                carry = inc && pm;
            end else if (hour[4:0] == 5'h12) begin
                nxt = {hour[7:5], 5'h01};
            end else begin
                nxt = {hour[7:5], inc12[4:0]};
            end
        end
    end

    // Hour register: host load has priority over counting
    always_ff @(posedge clk) begin
        if (!rst_n)
            hour <= 8'h12;
        else if (hit)
            hour <= wr.data;
        else if (inc)
            hour <= nxt;
    end

    // R6: 11 -> 12 toggles the PM flag in 12-hour mode
    a_r6_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !hit && !hour[7] && hour[4:0] == 5'h11
        |=> hour[5] != $past(hour[5]));
    // R6: 12 -> 01 keeps the PM flag
    a_r6_twelve_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !hit && !hour[7] && hour[4:0] == 5'h12
        |=> hour[4:0] == 5'h01 && $stable(hour[5]));
    // R5: 23 wraps to 00 in 24-hour mode
    a_r5_wrap23: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !hit && hour[7] && hour[5:0] == 6'h23 |=> hour[5:0] == 6'h00);

endmodule

// File: rtl/cal_date.sv
// Module: cal_date
// Day of week, date, month and two-digit year. Advances on inc (end of a
// day) using the month length and the divisible-by-four leap rule. Host
// writes load single fields. Assumes loaded values are valid BCD.
module cal_date
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  host_wr_t   wr,
    output logic [2:0] dow,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic [7:0] year
);
    logic [7:0] mlast;
    logic       month_end;
    logic       year_end;

    // End-of-month and end-of-year detection
    always_comb begin
        mlast     = last_day(month, year);
        month_end = (date >= mlast);
        year_end  = month_end && (month == 8'h12);
    end

    // Day-of-week counter 0..6
    always_ff @(posedge clk) begin
        if (!rst_n)
            dow <= 3'd0;
        else if (wr.en && wr.addr == ADR_DOW)
            dow <= wr.data[2:0];
        else if (inc)
            dow <= (dow == 3'd6) ? 3'd0 : dow + 3'd1;
    end

    // Date counter 01..last day of the month
    always_ff @(posedge clk) begin
        if (!rst_n)
            date <= 8'h01;
        else if (wr.en && wr.addr == ADR_DATE)
            date <= wr.data;
        else if (inc)
            date <= month_end ? 8'h01 : bcd_inc(date);
    end

    // Month counter 01..12
    always_ff @(posedge clk) begin
        if (!rst_n)
            month <= 8'h01;
        else if (wr.en && wr.addr == ADR_MONTH)
            month <= wr.data;
        else if (inc && month_end)
            month <= (month == 8'h12) ? 8'h01 : bcd_inc(month);
    end

    // Year counter 00..99
    always_ff @(posedge clk) begin
        if (!rst_n)
            year <= 8'h00;
        else if (wr.en && wr.addr == ADR_YEAR)
            year <= wr.data;
        else if (inc && year_end)
            year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end

    // R9: Feb 28 goes to Feb 29 in a year divisible by four
    a_r9_leap_day: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !wr.en && month == 8'h02 && date == 8'h28 && is_leap(year)
        |=> date == 8'h29 && month == 8'h02);
    // R7: day of week wraps from 6 to 0
    a_r7_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !wr.en && dow == 3'd6 |=> dow == 3'd0);
    // R10: year 99 wraps to 00 at the end of December
    a_r10_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !wr.en && year == 8'h99 && month == 8'h12 && date == 8'h31
        |=> year == 8'h00 && month == 8'h01);

endmodule

// File: rtl/cal_time_counter.sv
// Module: cal_time_counter (top)
// BCD calendar time counter. Holds the write-enable bit and the run
// state, qualifies host writes, and chains prescaler -> seconds ->
// minutes -> hour -> date. Assumes wr_done marks the end of a host
// transaction and that DIV >= 4.
module cal_time_counter
    import cal_pkg::*;
#(
    parameter int DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_wen_val,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              wr_done,
    output logic              tick_1hz,
    output logic [7:0]        t_sec,
    output logic [7:0]        t_min,
    output logic [7:0]        t_hour,
    output logic [2:0]        t_dow,
    output logic [7:0]        t_date,
    output logic [7:0]        t_month,
    output logic [7:0]        t_year
);
    localparam int N_SEXA = 2;
    localparam logic [ADDR_W-1:0] ADR_NONE = 3'd7;

    logic            wen_q;
    logic            running;
    logic            wr_ok;
    logic            done_ok;
    logic            adv;
    host_wr_t        wr;
    logic [N_SEXA:0] chain;
    logic [7:0]      sexa_val [N_SEXA];
    logic            day_inc;

    // Write-enable control bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            wen_q <= 1'b0;
        else if (ctl_we)
            wen_q <= ctl_wen_val;
    end

    // Write qualification and the advance strobe
    always_comb begin
        wr_ok    = host_we && wen_q && (host_addr != ADR_NONE);
        done_ok  = wr_done && wen_q;
        wr.en    = wr_ok;
        wr.addr  = host_addr;
        wr.data  = host_wdata;
        adv      = tick_1hz && !wr_ok;
        chain[0] = adv;
    end

    // Run state: a valid completion starts, an accepted write halts
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else if (done_ok)
            running <= 1'b1;
        else if (wr_ok)
            running <= 1'b0;
    end

    cal_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (done_ok),
        .tick    (tick_1hz)
    );

    generate
        for (genvar i = 0; i < N_SEXA; i++) begin : g_sexa
            cal_sexa #(.ADDR(ADR_SEC + ADDR_W'(i))) u_field (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (chain[i]),
                .wr    (wr),
                .value (sexa_val[i]),
                .carry (chain[i+1])
            );
        end
    endgenerate

    // Route the seconds and minutes fields to the ports
    always_comb begin
        t_sec = sexa_val[0];
        t_min = sexa_val[1];
    end

    cal_hour u_hour (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (chain[N_SEXA]),
        .wr    (wr),
        .hour  (t_hour),
        .carry (day_inc)
    );

    cal_date u_date (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (day_inc),
        .wr    (wr),
        .dow   (t_dow),
        .date  (t_date),
        .month (t_month),
        .year  (t_year)
    );

    // R2: a host write without the enable bit changes no field
    a_r2_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && !wen_q && !tick_1hz
        |=> $stable(t_sec) && $stable(t_min) && $stable(t_hour) && $stable(t_dow)
            && $stable(t_date) && $stable(t_month) && $stable(t_year));
    // R11: an accepted write halts counting (no tick next cycle)
    a_r11_halt: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok && !done_ok |=> !tick_1hz);
    // R11: the seconds written on a tick edge are kept as written
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok && host_addr == ADR_SEC |=> t_sec == $past(host_wdata));
    // R3: without the enable bit, wr_done does not start counting
    a_r3_done_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        !running && wr_done && !wen_q |=> !tick_1hz);

endmodule

// File: tb/sim_cal_time_counter.sv
// Bench for cal_time_counter: directed rollover corners plus seeded random
// times, compared each second against a binary model kept in the bench.
module sim_cal_time_counter;

    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic       ctl_wen_val = 1'b0;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic       wr_done = 1'b0;
    logic       tick_1hz;
    logic [7:0] t_sec, t_min, t_hour, t_date, t_month, t_year;
    logic [2:0] t_dow;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Model state (binary)
    int ms, mm, mh, mpm, m24, mdow, md, mmo, my;

    always #2 clk = ~clk;

    cal_time_counter #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wen_val(ctl_wen_val),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .wr_done(wr_done), .tick_1hz(tick_1hz), .t_sec(t_sec), .t_min(t_min),
        .t_hour(t_hour), .t_dow(t_dow), .t_date(t_date), .t_month(t_month),
        .t_year(t_year)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte();
        if (m24 != 0) return 8'h80 | to_bcd(mh);
        return ((mpm != 0) ? 8'h20 : 8'h00) | to_bcd(mh);
    endfunction

    task automatic next_day();
        mdow = (mdow + 1) % 7;
        md++;
        if (md > mdays(mmo, my)) begin
            md = 1;
            mmo++;
            if (mmo == 13) begin
                mmo = 1;
                my = (my + 1) % 100;
            end
        end
    endtask

    task automatic model_step();
        ms++;
        if (ms < 60) return;
        ms = 0;
        mm++;
        if (mm < 60) return;
        mm = 0;
        if (m24 != 0) begin
            mh++;
            if (mh == 24) begin
                mh = 0;
                next_day();
            end
        end else if (mh == 11) begin
            mh  = 12;
            mpm = 1 - mpm;
            if (mpm == 0) next_day();
        end else if (mh == 12) begin
            mh = 1;
        end else begin
            mh++;
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_all(input string req);
        chk(req, "sec",   t_sec,   to_bcd(ms));
        chk(req, "min",   t_min,   to_bcd(mm));
        chk(req, "hour",  t_hour,  hour_byte());
        chk(req, "dow",   {5'b0, t_dow}, 8'(mdow));
        chk(req, "date",  t_date,  to_bcd(md));
        chk(req, "month", t_month, to_bcd(mmo));
        chk(req, "year",  t_year,  to_bcd(my));
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_wen(input logic v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wen_val = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
    endtask

    // Load all fields (R12 address map) and complete the write
    task automatic load(input int s, input int m, input int h, input int pm,
                        input int md24, input int dw, input int d,
                        input int mo, input int y);
        ms = s; mm = m; mh = h; mpm = pm; m24 = md24;
        mdow = dw; md = d; mmo = mo; my = y;
        wr_reg(3'd0, to_bcd(s));
        wr_reg(3'd1, to_bcd(m));
        wr_reg(3'd2, hour_byte());
        wr_reg(3'd3, 8'(dw));
        wr_reg(3'd4, to_bcd(d));
        wr_reg(3'd5, to_bcd(mo));
        wr_reg(3'd6, to_bcd(y));
        pulse_done();
    endtask

    // First second after a completion: tick timing (R3) then values
    task automatic first_sec(input string req);
        repeat (DIV - 1) @(posedge clk);
        #1 chk("R3", "tick", {7'b0, tick_1hz}, 8'h01);
        @(posedge clk);
        #1 model_step();
        expect_all(req);
    endtask

    task automatic run_secs(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            repeat (DIV) @(posedge clk);
            #1 model_step();
            expect_all(req);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int s, m, h, pm, md24, d, mo, y;
        void'($urandom(32'd5813));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        ms = 0; mm = 0; mh = 12; mpm = 0; m24 = 0; mdow = 0; md = 1; mmo = 1; my = 0;
        #1 expect_all("R1");
        // R1: stopped after reset
        repeat (3 * DIV) @(posedge clk);
        #1 expect_all("R1");

        // R2: write without enable is ignored
        wr_reg(3'd0, 8'h33);
        #1 chk("R2", "sec", t_sec, 8'h00);
        // R3: completion without enable does not start counting
        pulse_done();
        repeat (3 * DIV) @(posedge clk);
        #1 expect_all("R3");
        chk("R3", "tick", {7'b0, tick_1hz}, 8'h00);

        set_wen(1'b1);
        // R5/R7/R10: end of century year in 24-hour mode
        load(58, 59, 23, 0, 1, 6, 31, 12, 99);
        first_sec("R5");
        run_secs(2, "R5/R7/R10");
        // R6: noon
        load(59, 59, 11, 0, 0, 2, 15, 6, 23);
        first_sec("R6");
        // R6/R8: midnight in 12-hour mode at end of April
        load(58, 59, 11, 1, 0, 3, 30, 4, 23);
        first_sec("R6");
        run_secs(1, "R6/R8");
        // R6: 12 -> 01 keeps PM
        load(59, 59, 12, 1, 0, 1, 10, 7, 31);
        first_sec("R6");
        // R9: leap February
        load(59, 59, 23, 0, 1, 4, 28, 2, 4);
        first_sec("R9");
        load(59, 59, 23, 0, 1, 4, 29, 2, 4);
        first_sec("R9");
        load(59, 59, 23, 0, 1, 5, 28, 2, 0);
        first_sec("R9");
        // R8: month lengths
        load(59, 59, 23, 0, 1, 5, 28, 2, 5);
        first_sec("R8");
        load(59, 59, 23, 0, 1, 0, 30, 9, 11);
        first_sec("R8");
        load(59, 59, 23, 0, 1, 0, 31, 1, 11);
        first_sec("R8");
        load(59, 59, 23, 0, 1, 0, 30, 1, 11);
        first_sec("R8");

        // R12: address 7 is ignored and does not halt counting
        load(30, 20, 10, 0, 1, 2, 3, 3, 12);
        wr_reg(3'd7, 8'h77);
        repeat (DIV - 2) @(posedge clk);
        #1 model_step();
        expect_all("R12");
        run_secs(1, "R12");

        // R2: enable cleared while running, write ignored, counting goes on
        load(10, 20, 10, 0, 1, 2, 3, 3, 12);
        set_wen(1'b0);
        wr_reg(3'd1, 8'h44);
        repeat (DIV - 3) @(posedge clk);
        #1 model_step();
        expect_all("R2");
        run_secs(1, "R2");
        set_wen(1'b1);

        // R11: write on the tick edge wins and halts counting
        load(40, 15, 8, 0, 1, 1, 9, 9, 9);
        repeat (DIV - 1) @(posedge clk);
        #1 chk("R11", "tick", {7'b0, tick_1hz}, 8'h01);
        wr_reg(3'd0, 8'h30);
        ms = 30;
        #1 expect_all("R11");
        repeat (2 * DIV) @(posedge clk);
        #1 expect_all("R11");
        pulse_done();
        first_sec("R11");
        run_secs(1, "R11");

        // R4: seeded random times near rollovers, both hour modes
        for (int k = 0; k < 24; k++) begin
            md24 = int'($urandom % 2);
            pm = int'($urandom % 2);
            if (md24 != 0) h = ($urandom % 2) ? 23 : int'($urandom % 24);
            else           h = ($urandom % 2) ? 11 : 1 + int'($urandom % 12);
            s  = 55 + int'($urandom % 5);
            m  = ($urandom % 2) ? 59 : int'($urandom % 60);
            mo = 1 + int'($urandom % 12);
            y  = int'($urandom % 100);
            d  = ($urandom % 2) ? mdays(mo, y) : 1 + int'($urandom % mdays(mo, y));
            load(s, m, h, pm, md24, int'($urandom % 7), d, mo, y);
            first_sec("R4");
            run_secs(5, "R4");
        end

        summary();
    end

endmodule